// File: doc/BRIEF.md
# Hash Engine Command and Status Register Block

This block is the software-facing front end of a hash accelerator. A host writes a word-addressed register file that holds the source, destination and key buffer addresses, the source length, a crypt command word, a hash command word and a status word. When the host writes the hash command, the block decodes a two-level algorithm selection. A valid selection launches the hash datapath with a one-cycle start pulse. The chosen algorithm, the scatter-gather flag and the accumulate flag go with the pulse and stay held on the outputs until the next launch. An unknown selection is stored but starts nothing.

The datapath reports the end of an operation with a one-cycle done pulse. The block then sets a sticky completion flag in the status word, whether or not interrupts are enabled. It raises its interrupt line only when the launched command asked for one. Software clears the flag and the line by writing a one to the flag bit. A busy indication in the status word covers the time from launch to completion, and command writes made during that time are dropped. Per-variant mask parameters set how many address bits are kept and which command bits exist.

Top module: `hce_ctrl`

## Requirements
- R1: After reset, every word reads zero, and start_o, irq_o, sg_o, accum_o and algo_o are all zero.
- R2: Written values are masked. Word 8 (source) keeps SRC_MASK (default 0x7FFFFFFF). Word 9 (destination) keeps DST_MASK (default 0x7FFFFFF8). Word 10 (key buffer) keeps KEY_MASK (default 0x7FFFFFF8). Word 11 (length) keeps bits [27:0]. Word 12 (hash command) keeps CMD_MASK (default 0x00147FFF). Word 4 (crypt command) keeps all 32 bits.
- R3: Word indices with no register, including every index at or above NUM_WORDS (16), read zero, and writes to them change no register.
- R4: The command algorithm field is bits [6:4] and the family sub-field is bits [12:10]. The only valid pairs (field, sub) and their algo_o codes are: (000,000) MD5 = 0, (010,000) SHA-1 = 1, (100,000) SHA-224 = 2, (101,000) SHA-256 = 3, (110,000) SHA-512 = 5, (110,001) SHA-384 = 4 and (110,010) SHA-256 = 3.
- R5: A command write accepted with any other pair updates word 12 but gives no start pulse and does not set busy.
- R6: An accepted valid command raises start_o for exactly the one cycle after the write. In that cycle sg_o equals command bit 18 and accum_o is 1 only when bits [8:7] equal 10. algo_o, sg_o and accum_o hold until the next start.
- R7: Status bit 0 (busy) reads 1 from the start pulse until the done pulse. A command write while busy is dropped: word 12 is unchanged and no start follows.
- R8: A done_i pulse while busy sets status bit 9 and clears busy, whatever command bit 9 is. A done_i pulse while idle changes nothing.
- R9: On a done_i pulse while busy, irq_o rises only if bit 9 of the launched command is 1. Once high, it stays high until software clears status bit 9.
- R10: Writing status with bit 9 = 1 clears status bit 9 and irq_o. Writing 0 there leaves both unchanged. No other status bit can be written.
- R11: When done_i (while busy) and a clearing status write fall in the same cycle, the completion wins: bit 9 ends set, and irq_o ends high if the launched command enabled it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; rdata is zero when low |
| addr | input | AW (6) | Word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr and rd_en |
| done_i | input | 1 | One-cycle completion pulse from the hash datapath |
| start_o | output | 1 | One-cycle launch pulse to the hash datapath |
| algo_o | output | 3 | Selected algorithm code per R4 |
| sg_o | output | 1 | Scatter-gather input enable for the launched operation |
| accum_o | output | 1 | Accumulate mode for the launched operation |
| irq_o | output | 1 | Completion interrupt |

## Verification
Two pairs of functions can meet in one cycle. In the first, the datapath's done pulse lands in the same cycle as a software write that clears the completion flag. In the second, it lands together with a new command write. The bench drives done_i and the register write on the same clock edge, both in directed cases and in a random collision operation. A bench model resolves each collision the way R11 and R7 require: the set wins over the clear, and the command is judged against the busy state before the edge. The model then compares irq_o, start_o and the status word read back afterwards.

// File: rtl/hce_pkg.sv
package hce_pkg;

  typedef enum logic [2:0] {
    ALG_MD5    = 3'd0,
    ALG_SHA1   = 3'd1,
    ALG_SHA224 = 3'd2,
    ALG_SHA256 = 3'd3,
    ALG_SHA384 = 3'd4,
    ALG_SHA512 = 3'd5
  } hce_alg_e;

  // word indices that the software map depends on
  localparam int W_CRYPT = 4;
  localparam int W_STAT  = 7;
  localparam int W_SRC   = 8;
  localparam int W_DST   = 9;
  localparam int W_KEY   = 10;
  localparam int W_LEN   = 11;
  localparam int W_CMD   = 12;

  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 9;
  localparam int C_IRQEN = 9;
  localparam int C_SG    = 18;

  localparam logic [31:0] LEN_KEEP = 32'h0FFF_FFFF;

endpackage

// File: rtl/hce_alg_decode.sv
module hce_alg_decode
  import hce_pkg::*;
(
  input  logic [2:0] fam_i,
  input  logic [2:0] sub_i,
  input  logic [1:0] mode_i,
  output logic       valid_o,
  output hce_alg_e   alg_o,
  output logic       accum_o
);

  always_comb begin
    valid_o = 1'b1;
    alg_o   = ALG_MD5;
    case ({sub_i, fam_i})
      6'b000_000: alg_o = ALG_MD5;
      6'b000_010: alg_o = ALG_SHA1;
      6'b000_100: alg_o = ALG_SHA224;
      6'b000_101: alg_o = ALG_SHA256;
      6'b000_110: alg_o = ALG_SHA512;
      6'b001_110: alg_o = ALG_SHA384;
      6'b010_110: alg_o = ALG_SHA256;
      default:    valid_o = 1'b0;
    endcase
    accum_o = (mode_i == 2'b10);
  end

endmodule

// File: rtl/hce_status_track.sv
module hce_status_track (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic irq_en_i,
  input  logic done_i,
  input  logic clr_i,
  output logic busy_o,
  output logic flag_o,
  output logic irq_o
);

  logic busy_q, busy_d;
  logic flag_q, flag_d;
  logic irq_q,  irq_d;
  logic fin;
  logic upd;

  assign fin = done_i && busy_q;
  assign upd = launch_i || fin || clr_i;

  always_comb begin
    busy_d = busy_q;
    flag_d = flag_q;
    irq_d  = irq_q;
    if (launch_i) busy_d = 1'b1;
    else if (fin) busy_d = 1'b0;
    if (fin)        flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
    if (fin && irq_en_i) irq_d = 1'b1;
    else if (clr_i)      irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (upd) begin
      busy_q <= busy_d;
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign busy_o = busy_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  // R9: the interrupt never stands without the completion flag
  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> flag_q);
  // R8: completion while busy sets the flag and ends busy
  a_r8_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && busy_q) |=> (flag_q && !busy_q));
  // R11: completion beats a same-cycle clear
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && busy_q && clr_i) |=> flag_q);
  // R10: a clear without completion drops flag and interrupt
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(done_i && busy_q)) |=> (!flag_q && !irq_q));
  // R8: an idle done pulse leaves the flag alone
  a_r8_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !busy_q && !clr_i) |=> $stable(flag_q));

endmodule

// File: rtl/hce_ctrl.sv
module hce_ctrl
  import hce_pkg::*;
#(
  parameter int          AW        = 6,
  parameter int          NUM_WORDS = 16,
  parameter logic [31:0] SRC_MASK  = 32'h7FFF_FFFF,
  parameter logic [31:0] DST_MASK  = 32'h7FFF_FFF8,
  parameter logic [31:0] KEY_MASK  = 32'h7FFF_FFF8,
  parameter logic [31:0] CMD_MASK  = 32'h0014_7FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          done_i,
  output logic          start_o,
  output logic [2:0]    algo_o,
  output logic          sg_o,
  output logic          accum_o,
  output logic          irq_o
);

  localparam int N_ADR = 4;
  localparam logic [31:0] ADR_MASKS [N_ADR] = '{SRC_MASK, DST_MASK, KEY_MASK, LEN_KEEP};

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  logic in_range;
  assign in_range = ({{(32-AW){1'b0}}, addr} < NUM_WORDS);

  // address/length words
  logic [31:0] adr_q [N_ADR];
  for (genvar g = 0; g < N_ADR; g++) begin : g_adr
    logic en;
    logic [31:0] d;
    assign en = wr_en && in_range && (addr == AW'(W_SRC + g));
    assign d  = wdata & ADR_MASKS[g];
    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns)  adr_q[g] <= '0;
      else if (en)  adr_q[g] <= d;
    end
  end

  // crypt command word, storage only
  logic [31:0] crypt_q;
  logic        crypt_wr;
  assign crypt_wr = wr_en && in_range && (addr == AW'(W_CRYPT));
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)       crypt_q <= '0;
    else if (crypt_wr) crypt_q <= wdata;
  end

  // hash command
  logic        cmd_wr, accept, launch, busy, flag, stat_clr;
  logic [31:0] cmd_d, cmd_q;
  logic        dec_valid, dec_accum;
  hce_alg_e    dec_alg;

  assign cmd_wr   = wr_en && in_range && (addr == AW'(W_CMD));
  assign cmd_d    = wdata & CMD_MASK;
  assign accept   = cmd_wr && !busy;
  assign launch   = accept && dec_valid;
  assign stat_clr = wr_en && in_range && (addr == AW'(W_STAT)) && wdata[ST_DONE];

  hce_alg_decode u_dec (
    .fam_i   (cmd_d[6:4]),
    .sub_i   (cmd_d[12:10]),
    .mode_i  (cmd_d[8:7]),
    .valid_o (dec_valid),
    .alg_o   (dec_alg),
    .accum_o (dec_accum)
  );

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     cmd_q <= '0;
    else if (accept) cmd_q <= cmd_d;
  end

  logic       start_q, sg_q, acc_q;
  hce_alg_e   alg_q;
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) start_q <= 1'b0;
    else         start_q <= launch;
  end
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      alg_q <= ALG_MD5;
      sg_q  <= 1'b0;
      acc_q <= 1'b0;
    end else if (launch) begin
      alg_q <= dec_alg;
      sg_q  <= cmd_d[C_SG];
      acc_q <= dec_accum;
    end
  end

  hce_status_track u_stat (
    .clk      (clk),
    .rst_n    (rst_ns),
    .launch_i (launch),
    .irq_en_i (cmd_q[C_IRQEN]),
    .done_i   (done_i),
    .clr_i    (stat_clr),
    .busy_o   (busy),
    .flag_o   (flag),
    .irq_o    (irq_o)
  );

  // read path
  logic [31:0] stat_w;
  always_comb begin
    stat_w          = '0;
    stat_w[ST_BUSY] = busy;
    stat_w[ST_DONE] = flag;
  end

  always_comb begin
    rdata = '0;
    if (rd_en && in_range) begin
      case (addr)
        AW'(W_CRYPT): rdata = crypt_q;
        AW'(W_STAT):  rdata = stat_w;
        AW'(W_SRC):   rdata = adr_q[0];
        AW'(W_DST):   rdata = adr_q[1];
        AW'(W_KEY):   rdata = adr_q[2];
        AW'(W_LEN):   rdata = adr_q[3];
        AW'(W_CMD):   rdata = cmd_q;
        default:      rdata = '0;
      endcase
    end
  end

  assign start_o = start_q;
  assign algo_o  = alg_q;
  assign sg_o    = sg_q;
  assign accum_o = acc_q;

  // R6: start lasts a single cycle
  a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_ns)
    start_o |=> !start_o);
  // R7: busy is already up while start is shown
  a_r7_busy_with_start: assert property (@(posedge clk) disable iff (!rst_ns)
    start_o |-> busy);
  // R5: an invalid accepted command gives no start
  a_r5_invalid_no_start: assert property (@(posedge clk) disable iff (!rst_ns)
    (cmd_wr && !busy && !dec_valid) |=> !start_o);
  // R7: command writes while busy are dropped
  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_ns)
    (cmd_wr && busy) |=> (!start_o && $stable(cmd_q)));
  // R6: qualifiers hold between starts
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    !start_o |-> ($stable(algo_o) && $stable(sg_o) && $stable(accum_o)));

endmodule

// File: tb/hce_ctrl_tb.sv
module hce_ctrl_tb;

  localparam int          AW = 6;
  localparam logic [31:0] M_SRC = 32'h7FFF_FFFF;
  localparam logic [31:0] M_DST = 32'h7FFF_FFF8;
  localparam logic [31:0] M_KEY = 32'h7FFF_FFF8;
  localparam logic [31:0] M_LEN = 32'h0FFF_FFFF;
  localparam logic [31:0] M_CMD = 32'h0014_7FFF;

  logic clk, rst_n, wr_en, rd_en, done_i;
  logic [AW-1:0] addr;
  logic [31:0] wdata, rdata;
  logic start_o, sg_o, accum_o, irq_o;
  logic [2:0] algo_o;

  int n_chk = 0;
  int n_fail = 0;

  hce_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .done_i(done_i), .start_o(start_o),
    .algo_o(algo_o), .sg_o(sg_o), .accum_o(accum_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // bench model
  logic [31:0] m_crypt, m_src, m_dst, m_key, m_len, m_cmd;
  logic m_busy, m_flag, m_irq, m_sg, m_acc;
  logic [2:0] m_alg;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic bit dec(input logic [31:0] c, output logic [2:0] a);
    a = 3'd0;
    case ({c[12:10], c[6:4]})
      6'o00: begin a = 3'd0; return 1'b1; end
      6'o02: begin a = 3'd1; return 1'b1; end
      6'o04: begin a = 3'd2; return 1'b1; end
      6'o05: begin a = 3'd3; return 1'b1; end
      6'o06: begin a = 3'd5; return 1'b1; end
      6'o16: begin a = 3'd4; return 1'b1; end
      6'o26: begin a = 3'd3; return 1'b1; end
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_word(input int a);
    logic [31:0] s;
    s = '0;
    s[0] = m_busy;
    s[9] = m_flag;
    case (a)
      4: return m_crypt;
      7: return s;
      8: return m_src;
      9: return m_dst;
      10: return m_key;
      11: return m_len;
      12: return m_cmd;
      default: return '0;
    endcase
  endfunction

  // one bus cycle: optional write, optional done pulse in the same cycle
  task automatic cyc(input bit we, input int a, input logic [31:0] d, input bit dn, input string req);
    logic old_busy, set, clr, launch, v, en_irq;
    logic [2:0] al;
    logic [31:0] c;
    @(negedge clk);
    wr_en = we; addr = AW'(a); wdata = d; done_i = dn;
    old_busy = m_busy; en_irq = m_cmd[9];
    clr = 1'b0; launch = 1'b0;
    if (we) begin
      case (a)
        4: m_crypt = d;
        8: m_src = d & M_SRC;
        9: m_dst = d & M_DST;
        10: m_key = d & M_KEY;
        11: m_len = d & M_LEN;
        7: clr = d[9];
        12: if (!old_busy) begin
              c = d & M_CMD;
              m_cmd = c;
              v = dec(c, al);
              if (v) begin
                launch = 1'b1;
                m_alg = al; m_sg = c[18]; m_acc = (c[8:7] == 2'b10);
              end
            end
        default: ;
      endcase
    end
    set = dn && old_busy;
    if (set) m_flag = 1'b1; else if (clr) m_flag = 1'b0;
    if (set && en_irq) m_irq = 1'b1; else if (clr) m_irq = 1'b0;
    if (launch) m_busy = 1'b1; else if (set) m_busy = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; done_i = 1'b0;
    chk(req, "start_o", 32'(start_o), 32'(launch));
    chk(req, "irq_o", 32'(irq_o), 32'(m_irq));
    if (launch) begin
      chk(req, "algo_o", 32'(algo_o), 32'(m_alg));
      chk(req, "sg_o", 32'(sg_o), 32'(m_sg));
      chk(req, "accum_o", 32'(accum_o), 32'(m_acc));
    end
  endtask

  task automatic rd(input int a, input string req);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    #1;
    chk(req, $sformatf("word %0d", a), rdata, exp_word(a));
    rd_en = 1'b0;
  endtask

  function automatic logic [31:0] mkcmd(input logic [2:0] fam, input logic [2:0] sub,
                                        input logic [1:0] mode, input bit irq, input bit sg);
    logic [31:0] c;
    c = $urandom;
    c[6:4] = fam; c[12:10] = sub; c[8:7] = mode; c[9] = irq; c[18] = sg;
    return c;
  endfunction

  initial begin
    #(8*150000);
    n_fail++;
    $display("FAIL all: watchdog expired, actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    wr_en = 0; rd_en = 0; done_i = 0; addr = '0; wdata = '0;
    m_crypt = 0; m_src = 0; m_dst = 0; m_key = 0; m_len = 0; m_cmd = 0;
    m_busy = 0; m_flag = 0; m_irq = 0; m_sg = 0; m_acc = 0; m_alg = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 16; i++) rd(i, "R1");
    chk("R1", "outputs", {27'd0, start_o, irq_o, sg_o, accum_o, |algo_o}, 32'd0);

    // R2: masking
    cyc(1, 8, 32'hFFFF_FFFF, 0, "R2"); rd(8, "R2");
    cyc(1, 9, 32'hFFFF_FFFF, 0, "R2"); rd(9, "R2");
    cyc(1, 10, 32'hFFFF_FFFF, 0, "R2"); rd(10, "R2");
    cyc(1, 11, 32'hFFFF_FFFF, 0, "R2"); rd(11, "R2");
    cyc(1, 4, 32'hDEAD_BEEF, 0, "R2"); rd(4, "R2");

    // R3: aliasing index above range and unmapped index
    cyc(1, 24, 32'h1234_5670, 0, "R3"); rd(8, "R3"); rd(24, "R3");
    cyc(1, 5, 32'hFFFF_FFFF, 0, "R3"); rd(5, "R3"); rd(63, "R3");

    // R4 / R6: each valid pair, then completion
    begin
      logic [2:0] fams [7] = '{3'b000, 3'b010, 3'b100, 3'b101, 3'b110, 3'b110, 3'b110};
      logic [2:0] subs [7] = '{3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b001, 3'b010};
      for (int i = 0; i < 7; i++) begin
        cyc(1, 12, mkcmd(fams[i], subs[i], 2'(i % 4), 0, i[0]), 0, "R4");
        rd(12, "R6");
        cyc(0, 0, 0, 1, "R8");
      end
    end

    // R5: invalid pairs
    cyc(1, 12, mkcmd(3'b000, 3'b001, 2'b00, 0, 0), 0, "R5"); rd(12, "R5"); rd(7, "R5");
    cyc(1, 12, mkcmd(3'b110, 3'b011, 2'b10, 0, 0), 0, "R5");
    cyc(1, 12, mkcmd(3'b111, 3'b000, 2'b00, 0, 0), 0, "R5");
    cyc(1, 12, mkcmd(3'b001, 3'b000, 2'b00, 0, 0), 0, "R5"); rd(7, "R5");

    // R7: busy blocks command writes
    cyc(1, 12, mkcmd(3'b010, 3'b000, 2'b10, 1, 1), 0, "R7"); rd(7, "R7");
    cyc(1, 12, mkcmd(3'b100, 3'b000, 2'b00, 0, 0), 0, "R7"); rd(12, "R7");
    // R8 / R9: completion with interrupt enabled
    cyc(0, 0, 0, 1, "R9"); rd(7, "R8");
    cyc(0, 0, 0, 1, "R8"); rd(7, "R8");
    // R10: zero write keeps, one write clears
    cyc(1, 7, 32'hFFFF_FDFF, 0, "R10"); rd(7, "R10");
    cyc(1, 7, 32'h0000_0200, 0, "R10"); rd(7, "R10");
    // R8: completion with interrupt disabled sets the flag only
    cyc(1, 12, mkcmd(3'b000, 3'b000, 2'b00, 0, 0), 0, "R8");
    cyc(0, 0, 0, 1, "R8"); rd(7, "R8");
    // R11: completion and clear in one cycle
    cyc(1, 12, mkcmd(3'b101, 3'b000, 2'b01, 1, 0), 0, "R11");
    cyc(1, 7, 32'h0000_0200, 1, "R11"); rd(7, "R11");
    cyc(1, 7, 32'h0000_0200, 0, "R10");
    // R7: completion and a new command in one cycle: command dropped
    cyc(1, 12, mkcmd(3'b010, 3'b000, 2'b00, 0, 0), 0, "R7");
    cyc(1, 12, mkcmd(3'b100, 3'b000, 2'b00, 0, 0), 1, "R7"); rd(12, "R7"); rd(7, "R7");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom % 7;
      case (op)
        0: cyc(1, $urandom % 64, $urandom, 0, "R2");
        1: rd($urandom % 64, "R3");
        2: cyc(1, 12, mkcmd(3'($urandom), 3'($urandom % 4), 2'($urandom), $urandom % 2, $urandom % 2), 0, "R4");
        3: cyc(0, 0, 0, 1, "R8");
        4: cyc(1, 7, $urandom, 0, "R10");
        5: cyc(1, 7, $urandom, 1, "R11");
        default: cyc(1, 12, mkcmd(3'b110, 3'($urandom % 4), 2'($urandom), 1, 0), $urandom % 2, "R7");
      endcase
      if (n % 5 == 0) rd(7, "R7");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule